// File: doc/BRIEF.md
# Multichannel DAC Gain-Offset Calibrator

This block is the digital side of a bank of voltage DAC channels. A writer presents a channel number, a two-bit target code and a data word. The word lands in one of three per-channel registers: the raw input code, the offset coefficient or the gain coefficient. A fourth target code is reserved for chip-level settings. A write to that code raises a one-cycle flag and touches no channel.

Every channel continuously forms a corrected code from its three registers. The corrected code is `x2 = floor((m + 2) * x1 / 16384) + (c - 8192)`, clamped to the 14-bit code range. The result is held in a per-channel staging register. A load strobe copies all staging registers into the DAC-side registers on the same clock edge, so every output changes together. The corrected DAC codes of all channels leave the block on one flat bus, with channel k at bits `[14k+13:14k]`.

Top module: `dac_cal_frontend`

## Requirements
- R1: On a write with `wr_en` high, `wr_sel` picks the target register of channel `wr_addr`: 2'b11 writes the raw input code x1, 2'b10 writes the offset c and 2'b01 writes the gain m. Other channels are unchanged.
- R2: The corrected code of a channel equals `floor((m + 2) * x1 / 2^14) + c - 2^13`, with 14-bit x1, m and c. The product is 15 by 14 bits and its upper 14 bits are kept.
- R3: After reset the gain is 0x3FFE and the offset is 0x2000, so a channel whose only write was x1 outputs x1 unchanged after a load.
- R4: Bit 0 of a written gain word is ignored, and the stored gain always has bit 0 clear. Writing 0x1FFF with x1 = 16383 and the default offset yields 8191.
- R5: The corrected code saturates: sums above 16383 give 16383, and sums below 0 give 0. Values never wrap.
- R6: `dac_codes` holds its value while `load` is low. On a clock edge with `load` high, every channel takes its staged corrected code at that same edge.
- R7: A gain or offset write recomputes the staged code from the channel's current x1. The output changes only at a following load.
- R8: A write with `wr_sel` = 2'b00 makes `sfr_write` high for exactly the next cycle and changes no channel register. `sfr_write` is low in every other cycle.
- R9: Reset (`rst_n` low) clears every x1 and every DAC register, so `dac_codes` reads all zeros after reset.
- R10: The staging register follows a register write one clock edge later. A load sampled on the second edge after the write, or on any later edge, transfers the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | AW (5) | Target channel number |
| wr_sel | input | 2 | Target register code: 11 input code, 10 offset, 01 gain, 00 chip-level |
| wr_data | input | DW (14) | Write data word |
| load | input | 1 | Synchronous transfer of all staged codes to the DAC registers |
| sfr_write | output | 1 | One-cycle flag for a chip-level register write |
| dac_codes | output | NCH*DW (448) | Corrected DAC codes, channel k at bits [DW*k+DW-1:DW*k] |

## Verification
Any wrong internal state stays hidden until a load, because the only data path to the ports runs through the DAC registers. So every register write is followed by a load, and then all channels are compared, not just the one written. A misrouted select code or address shows up as a wrong value on a neighbouring channel within three cycles of the write. A broken gain, offset or clamp term shows up as an off-value or a wrapped code at that same load. Errors in the staging timing or in the hold behaviour show up as a code that changes without a load, or that is still old after one.

// File: rtl/dcal_pkg.sv
// Package: shared register-select codes for the calibrating DAC front end.
// Assumes: the two-bit code values are fixed by the neighbouring bus decoder.
package dcal_pkg;

    typedef enum logic [1:0] {
        SEL_CHIP = 2'b00,
        SEL_GAIN = 2'b01,
        SEL_OFFS = 2'b10,
        SEL_CODE = 2'b11
    } dcal_sel_e;

endpackage

// File: rtl/dcal_decode.sv
// Module: dcal_decode
// Turns one write request into per-channel write enables for the three
// coefficient registers, and registers a one-cycle chip-level write flag.
// Assumes: wr_addr values at or above NCH select no channel.
module dcal_decode
    import dcal_pkg::*;
#(
    parameter int NCH = 32,
    parameter int AW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [1:0]     wr_sel,
    output logic [NCH-1:0] code_we,
    output logic [NCH-1:0] gain_we,
    output logic [NCH-1:0] offs_we,
    output logic           chip_pulse
);

    logic sel_code;
    logic sel_gain;
    logic sel_offs;
    logic sel_chip;

    // Purpose: classify the select field once for all channels.
    always_comb begin
        sel_code = wr_en && (dcal_sel_e'(wr_sel) == SEL_CODE);
        sel_gain = wr_en && (dcal_sel_e'(wr_sel) == SEL_GAIN);
        sel_offs = wr_en && (dcal_sel_e'(wr_sel) == SEL_OFFS);
        sel_chip = wr_en && (dcal_sel_e'(wr_sel) == SEL_CHIP);
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_en
            logic hit;
            // Purpose: match this channel's address against the request.
            always_comb begin
                hit        = (wr_addr == AW'(g));
                code_we[g] = sel_code && hit;
                gain_we[g] = sel_gain && hit;
                offs_we[g] = sel_offs && hit;
            end
        end
    endgenerate

    // Purpose: register the chip-level write flag for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) chip_pulse <= 1'b0;
        else        chip_pulse <= sel_chip;
    end

endmodule

// File: rtl/dcal_correct.sv
// Module: dcal_correct
// Combinational gain/offset correction with clamping to the code range.
// Computes floor((m+2)*x1 / 2^DW) + c - 2^(DW-1).
// Assumes: m is at most 2^DW - 2, so m + 2 fits in DW + 1 bits.
module dcal_correct #(
    parameter int DW = 14
) (
    input  logic [DW-1:0] x1,
    input  logic [DW-1:0] gain,
    input  logic [DW-1:0] offs,
    output logic [DW-1:0] code
);

    localparam int PW   = 2 * DW + 1;
    localparam int SW   = DW + 2;
    localparam int MID  = 1 << (DW - 1);
    localparam int MAXC = (1 << DW) - 1;

    logic [DW:0]          gain_p2;
    logic [PW-1:0]        prod;
    logic [DW-1:0]        scaled;
    logic signed [SW-1:0] sum;

    // Purpose: scale by the gain factor, add the signed offset, clamp.
    always_comb begin
        gain_p2 = {1'b0, gain} + (DW+1)'(2);
        prod    = PW'(gain_p2) * PW'(x1);
        scaled  = prod[2*DW-1:DW];
        sum     = $signed({2'b00, scaled}) + $signed({2'b00, offs})
                - $signed(SW'(MID));
        if (sum < 0)
            code = '0;
        else if (sum > $signed(SW'(MAXC)))
            code = DW'(MAXC);
        else
            code = sum[DW-1:0];
    end

endmodule

// File: rtl/dcal_channel.sv
// Module: dcal_channel
// One DAC channel: input code, gain and offset registers, a staging register
// that tracks the corrected code, and the DAC register loaded by a strobe.
// Assumes: at most one of the three write enables is high in a cycle.
module dcal_channel #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          code_we,
    input  logic          gain_we,
    input  logic          offs_we,
    input  logic [DW-1:0] wr_data,
    input  logic          load,
    output logic [DW-1:0] staged,
    output logic [DW-1:0] dac_q
);

    localparam logic [DW-1:0] GAIN_RST = {{(DW-1){1'b1}}, 1'b0};
    localparam logic [DW-1:0] OFFS_RST = DW'(1) << (DW - 1);

    logic [DW-1:0] x1_q;
    logic [DW-1:0] gain_q;
    logic [DW-1:0] offs_q;
    logic [DW-1:0] corr;

    // Purpose: hold the three coefficient registers; gain bit 0 stays zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x1_q   <= '0;
            gain_q <= GAIN_RST;
            offs_q <= OFFS_RST;
        end else begin
            if (code_we) x1_q   <= wr_data;
            if (gain_we) gain_q <= {wr_data[DW-1:1], 1'b0};
            if (offs_we) offs_q <= wr_data;
        end
    end

    dcal_correct #(.DW(DW)) u_corr (
        .x1   (x1_q),
        .gain (gain_q),
        .offs (offs_q),
        .code (corr)
    );

    // Purpose: input-side buffer follows the corrected code every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) staged <= '0;
        else        staged <= corr;
    end

    // Purpose: DAC-side register takes the staged code on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    dac_q <= '0;
        else if (load) dac_q <= staged;
    end

endmodule

// File: rtl/dac_cal_frontend.sv
// Module: dac_cal_frontend (top)
// Digital front end of a multichannel calibrated DAC: decodes register writes,
// corrects each channel's code with its gain/offset, and loads all channels
// together on a load strobe.
// Assumes: one write per cycle; load may coincide with a write (old code moves).
module dac_cal_frontend #(
    parameter int NCH = 32,
    parameter int DW  = 14,
    parameter int AW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [1:0]        wr_sel,
    input  logic [DW-1:0]     wr_data,
    input  logic              load,
    output logic              sfr_write,
    output logic [NCH*DW-1:0] dac_codes
);

    localparam int FW = NCH * DW;

    logic [NCH-1:0] code_we;
    logic [NCH-1:0] gain_we;
    logic [NCH-1:0] offs_we;
    logic [FW-1:0]  pend_flat;

    dcal_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_sel     (wr_sel),
        .code_we    (code_we),
        .gain_we    (gain_we),
        .offs_we    (offs_we),
        .chip_pulse (sfr_write)
    );

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            dcal_channel #(.DW(DW)) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .code_we (code_we[g]),
                .gain_we (gain_we[g]),
                .offs_we (offs_we[g]),
                .wr_data (wr_data),
                .load    (load),
                .staged  (pend_flat[g*DW +: DW]),
                .dac_q   (dac_codes[g*DW +: DW])
            );
        end
    endgenerate

endmodule

// File: rtl/dcal_chk.sv
// Module: dcal_chk
// Protocol checks for dac_cal_frontend, attached with bind below.
module dcal_chk #(
    parameter int FW = 448
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_sel,
    input logic          load,
    input logic          sfr_write,
    input logic [FW-1:0] pend_flat,
    input logic [FW-1:0] dac_codes
);

    // R8
    chip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b00) |=> sfr_write);

    // R8
    chip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'b00) |=> !sfr_write);

    // R6
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dac_codes));

    // R6
    dac_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dac_codes == $past(pend_flat)));

    // R9
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_codes == '0));

endmodule

bind dac_cal_frontend dcal_chk #(.FW(NCH*DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .load      (load),
    .sfr_write (sfr_write),
    .pend_flat (pend_flat),
    .dac_codes (dac_codes)
);

// File: tb/dac_cal_frontend_bench.sv
module dac_cal_frontend_bench;

    localparam int NCH = 4;
    localparam int DW  = 14;
    localparam int AW  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [1:0]        wr_sel = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              load = 1'b0;
    logic              sfr_write;
    logic [NCH*DW-1:0] dac_codes;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int mx1 [NCH];
    int mg  [NCH];
    int mc  [NCH];
    int mdac[NCH];

    always #2 clk = ~clk;

    dac_cal_frontend #(.NCH(NCH), .DW(DW), .AW(AW)) u_dac_cal_frontend (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .load      (load),
        .sfr_write (sfr_write),
        .dac_codes (dac_codes)
    );

    function automatic int model(int x1, int g, int c);
        int s;
        s = ((((g & 16382) + 2) * x1) >>> 14) + c - 8192;
        if (s < 0) s = 0;
        if (s > 16383) s = 16383;
        return s;
    endfunction

    task automatic check(input int got, input int exp, input string req);
        n_vec++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < NCH; k++)
            check(int'(dac_codes[k*DW +: DW]), mdac[k], req);
    endtask

    task automatic wr(input int ch, input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(ch); wr_sel = 2'(sel); wr_data = DW'(data);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            3: mx1[ch] = data;
            2: mc[ch]  = data;
            1: mg[ch]  = data & 16382;
            default: ;
        endcase
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load();
        idle();
        load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        for (int k = 0; k < NCH; k++) mdac[k] = model(mx1[k], mg[k], mc[k]);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NCH; k++) begin
            mx1[k] = 0; mg[k] = 16382; mc[k] = 8192; mdac[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: all outputs zero after reset
        check_all("R9");
        check(int'(sfr_write), 0, "R8");

        // R3: defaults give unity gain and zero offset
        wr(0, 3, 1234);
        do_load();
        check(int'(dac_codes[0 +: DW]), 1234, "R3");
        check_all("R3");

        // R6: no change without load
        wr(1, 3, 500);
        idle(); idle();
        check(int'(dac_codes[DW +: DW]), 0, "R6");
        do_load();
        check_all("R6");

        // R10: load on the first edge after a write moves the old staged code
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_sel = 2'b11; wr_data = 14'd900;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        check(int'(dac_codes[DW +: DW]), 500, "R10");
        load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        check(int'(dac_codes[DW +: DW]), 900, "R10");
        mx1[1] = 900; mdac[1] = 900;

        // R8: chip-level write pulses once and changes no channel
        wr(0, 0, 16383);
        check(int'(sfr_write), 1, "R8");
        idle();
        check(int'(sfr_write), 0, "R8");
        do_load();
        check_all("R8");

        // R4: gain bit 0 ignored
        wr(2, 3, 16383);
        wr(2, 1, 8191);
        do_load();
        check(int'(dac_codes[2*DW +: DW]), 8191, "R4");

        // R5: clamp high and low
        wr(3, 3, 16383);
        wr(3, 2, 16383);
        do_load();
        check(int'(dac_codes[3*DW +: DW]), 16383, "R5");
        wr(3, 3, 5);
        wr(3, 2, 0);
        do_load();
        check(int'(dac_codes[3*DW +: DW]), 0, "R5");

        // R7: gain write recomputes from current x1, visible only after load
        wr(0, 1, 4094);
        idle(); idle();
        check(int'(dac_codes[0 +: DW]), 1234, "R7");
        do_load();
        check(int'(dac_codes[0 +: DW]), model(1234, 4094, 8192), "R7");

        // R1, R2: sweep over channels, selects and coefficients
        for (int i = 0; i < 400; i++) begin
            int ch;
            ch = i % NCH;
            case (i % 3)
                0: begin
                    wr(ch, 3, (i * 7919 + 13) & 16383);
                    wr(ch, 1, (i * 4099 + 5) & 16383);
                    wr(ch, 2, (i * 2731 + 77) & 16383);
                end
                1: begin
                    wr(ch, 2, (i * 613 + 8000) & 16383);
                    wr(ch, 3, (i * 911) & 16383);
                end
                default: begin
                    wr(ch, 1, 16382 - ((i * 37) & 4095));
                    wr(ch, 3, 16383 - ((i * 53) & 16383));
                end
            endcase
            do_load();
            check_all("R1,R2");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule